// File: doc/BRIEF.md
# CPU Core Clock Speed Controller

This block produces the clock enable for a processor core. The source is one of three clock-tick inputs: the main oscillator, a real-time-clock oscillator or a PLL multiplier. The block divides the chosen source by a power of two between 1 and 128. The oscillator and the PLL are modelled as tick strobes on the system clock, each with a clock-valid flag. Source selection is synchronous and works on enables, so no analog clock mux is involved. A timer enable output follows the chosen source at its undivided rate.

The core changes speed by issuing a single 8-bit command. The command sets the divisor and the source, and it can also request that the main oscillator or the PLL be shut down. The block keeps a normal setting and a separate interrupt setting. The interrupt setting is loaded through its own strobe. On interrupt entry the block moves to the interrupt setting, and it returns to the normal setting when the outermost service routine ends. A command takes effect only at the next wrap of the divide counter. The command therefore finishes under the divisor that was active when it was issued, and no core pulse is shortened or repeated.

Top module: `cpu_clk_speed`

## Requirements
- R1: Bits [2:0] of a setting give the exponent e. Consecutive `core_en` pulses are spaced P·2^e cycles apart, where P is the tick period of the active source.
- R2: `timer_en` repeats every tick of the active source one cycle later, with no division. `core_en` is asserted only in cycles where `timer_en` is also asserted.
- R3: Bits [4:3] select the source: 00 is the main oscillator, 01 is the RTC oscillator, 10 is the PLL. Code 11 is reserved and is never made active.
- R4: When the active setting has bit 5 set, `main_osc_off` is high. When it has bit 6 set, `pll_off` is high. Each bit acts on its own.
- R5: An accepted command does not change the spacing of the first `core_en` pulse that follows it. The new spacing applies from that pulse onward.
- R6: `irq_enter` moves the block to the interrupt setting. After as many `irq_return` pulses as there were entries, the normal setting is in force again.
- R7: During and after reset the active setting is the main oscillator, exponent 0, with both off outputs low.
- R8: A write is rejected in any of these cases: the source code is 11, bit 7 is set, the chosen source's valid input is low, or the chosen source's own shutdown bit is set (bit 5 with the main oscillator, bit 6 with the PLL). A rejected write leaves every setting unchanged and raises `cmd_err` for exactly one cycle.
- R9: The active setting changes only in a cycle where `core_en` is asserted. The divide counter restarts at that point.
- R10: `isr_wr` with `isr_data` loads the interrupt setting, using the encoding of R1, R3 and R4. Nested entries keep the saved normal setting. An `irq_return` with no interrupt in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | Main oscillator tick strobe |
| rtc_tick | input | 1 | RTC oscillator tick strobe |
| pll_tick | input | 1 | PLL output tick strobe |
| main_valid | input | 1 | Main oscillator running |
| rtc_valid | input | 1 | RTC oscillator running |
| pll_valid | input | 1 | PLL locked |
| cmd_valid | input | 1 | Speed command strobe (normal setting) |
| cmd_data | input | 8 | Speed command value |
| isr_wr | input | 1 | Interrupt setting write strobe |
| isr_data | input | 8 | Interrupt setting value |
| irq_enter | input | 1 | Interrupt routine entered |
| irq_return | input | 1 | Interrupt routine returned |
| core_en | output | 1 | Divided core clock enable |
| timer_en | output | 1 | Undivided source enable for timers |
| main_osc_off | output | 1 | Request main oscillator shutdown |
| pll_off | output | 1 | Request PLL shutdown |
| cmd_err | output | 1 | One-cycle rejection flag |
| cur_src | output | 2 | Active source code |
| cur_div_exp | output | 3 | Active divisor exponent |

## Verification
The assertions check four properties on every cycle. The active setting changes only in a `core_en` cycle. `core_en` appears only together with a source tick on `timer_en`. A shutdown output is never raised for the source in use, and the reserved source code never becomes active. They also check that `cmd_err` follows a write and that the reset state is correct. Some behaviours can only be shown by the directed scenarios: exact pulse spacing for each divisor and source, the old spacing persisting through the boundary after a command, the unchanged setting after each kind of rejection, and the nesting count across entries and returns.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'b00,
    SRC_RTC  = 2'b01,
    SRC_PLL  = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;

  // Field order equals the command bit layout [6:0].
  typedef struct packed {
    logic       pll_off;
    logic       main_off;
    src_e       src;
    logic [2:0] div_exp;
  } speed_t;

  localparam speed_t SPEED_RESET = '{pll_off: 1'b0, main_off: 1'b0, src: SRC_MAIN, div_exp: 3'd0};
endpackage

// File: rtl/spd_decode.sv
module spd_decode
  import spd_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic             main_valid,
  input  logic             rtc_valid,
  input  logic             pll_valid,
  output speed_t           cfg,
  output logic             ok
);
  localparam int CFG_W = $bits(speed_t);

  always_comb begin
    cfg = speed_t'(cmd[CFG_W-1:0]);
    ok  = (cmd[CMD_W-1:CFG_W] == '0);
    unique case (cfg.src)
      SRC_MAIN: ok = ok && main_valid && !cfg.main_off;
      SRC_RTC:  ok = ok && rtc_valid;
      SRC_PLL:  ok = ok && pll_valid && !cfg.pll_off;
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/spd_regs.sv
module spd_regs
  import spd_pkg::*;
#(
  parameter int NEST_W = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   cmd_valid,
  input  logic   cmd_ok,
  input  speed_t cmd_cfg,
  input  logic   isr_wr,
  input  logic   isr_ok,
  input  speed_t isr_cfg,
  input  logic   irq_enter,
  input  logic   irq_return,
  output speed_t target,
  output logic   cmd_err
);
  localparam logic [NEST_W-1:0] NEST_MAX = '1;

  speed_t            norm_q, isr_q;
  logic [NEST_W-1:0] depth_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      norm_q  <= SPEED_RESET;
      isr_q   <= SPEED_RESET;
      depth_q <= '0;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= (cmd_valid && !cmd_ok) || (isr_wr && !isr_ok);
      if (cmd_valid && cmd_ok) norm_q <= cmd_cfg;
      if (isr_wr && isr_ok)    isr_q  <= isr_cfg;
      if (irq_enter && !irq_return && depth_q != NEST_MAX)
        depth_q <= depth_q + 1'b1;
      else if (irq_return && !irq_enter && depth_q != '0)
        depth_q <= depth_q - 1'b1;
    end
  end

  assign target = (depth_q != '0) ? isr_q : norm_q;
endmodule

// File: rtl/spd_divider.sv
module spd_divider
  import spd_pkg::*;
#(
  parameter int EXP_W = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   main_tick,
  input  logic   rtc_tick,
  input  logic   pll_tick,
  input  speed_t target,
  output speed_t active,
  output logic   core_en,
  output logic   timer_en
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] cnt_q, term;
  logic             tick_sel, wrap;

  always_comb begin
    unique case (active.src)
      SRC_MAIN: tick_sel = main_tick;
      SRC_RTC:  tick_sel = rtc_tick;
      SRC_PLL:  tick_sel = pll_tick;
      default:  tick_sel = 1'b0;
    endcase
    term = (CNT_W'(1) << active.div_exp) - CNT_W'(1);
    wrap = tick_sel && (cnt_q == term);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= SPEED_RESET;
      cnt_q    <= '0;
      core_en  <= 1'b0;
      timer_en <= 1'b0;
    end else begin
      timer_en <= tick_sel;
      core_en  <= wrap;
      if (wrap) begin
        cnt_q  <= '0;
        active <= target;
      end else if (tick_sel) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpu_clk_speed.sv
module cpu_clk_speed
  import spd_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int EXP_W  = 3,
  parameter int NEST_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             main_tick,
  input  logic             rtc_tick,
  input  logic             pll_tick,
  input  logic             main_valid,
  input  logic             rtc_valid,
  input  logic             pll_valid,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             isr_wr,
  input  logic [CMD_W-1:0] isr_data,
  input  logic             irq_enter,
  input  logic             irq_return,
  output logic             core_en,
  output logic             timer_en,
  output logic             main_osc_off,
  output logic             pll_off,
  output logic             cmd_err,
  output logic [1:0]       cur_src,
  output logic [EXP_W-1:0] cur_div_exp
);
  speed_t cmd_cfg, isr_cfg, target, active;
  logic   cmd_ok, isr_ok;

  spd_decode #(.CMD_W(CMD_W)) u_dec_cmd (
    .cmd(cmd_data), .main_valid(main_valid), .rtc_valid(rtc_valid),
    .pll_valid(pll_valid), .cfg(cmd_cfg), .ok(cmd_ok)
  );

  spd_decode #(.CMD_W(CMD_W)) u_dec_isr (
    .cmd(isr_data), .main_valid(main_valid), .rtc_valid(rtc_valid),
    .pll_valid(pll_valid), .cfg(isr_cfg), .ok(isr_ok)
  );

  spd_regs #(.NEST_W(NEST_W)) u_regs (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ok(cmd_ok),
    .cmd_cfg(cmd_cfg), .isr_wr(isr_wr), .isr_ok(isr_ok), .isr_cfg(isr_cfg),
    .irq_enter(irq_enter), .irq_return(irq_return), .target(target),
    .cmd_err(cmd_err)
  );

  spd_divider #(.EXP_W(EXP_W)) u_div (
    .clk(clk), .rst(rst), .main_tick(main_tick), .rtc_tick(rtc_tick),
    .pll_tick(pll_tick), .target(target), .active(active),
    .core_en(core_en), .timer_en(timer_en)
  );

  assign main_osc_off = active.main_off;
  assign pll_off      = active.pll_off;
  assign cur_src      = active.src;
  assign cur_div_exp  = active.div_exp;
endmodule

// File: rtl/cpu_clk_speed_chk.sv
module cpu_clk_speed_chk #(
  parameter int EXP_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             main_tick,
  input logic             rtc_tick,
  input logic             pll_tick,
  input logic             cmd_valid,
  input logic             isr_wr,
  input logic             core_en,
  input logic             timer_en,
  input logic             main_osc_off,
  input logic             pll_off,
  input logic             cmd_err,
  input logic [1:0]       cur_src,
  input logic [EXP_W-1:0] cur_div_exp
);
  // R2
  core_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
    core_en |-> timer_en);

  // R2
  timer_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
    timer_en |-> $past(main_tick || rtc_tick || pll_tick));

  // R9
  switch_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({cur_src, cur_div_exp, main_osc_off, pll_off}) |-> core_en);

  // R4
  main_off_unused_chk: assert property (@(posedge clk) disable iff (rst)
    main_osc_off |-> cur_src != 2'b00);

  // R4
  pll_off_unused_chk: assert property (@(posedge clk) disable iff (rst)
    pll_off |-> cur_src != 2'b10);

  // R3
  no_reserved_src_chk: assert property (@(posedge clk) disable iff (rst)
    cur_src != 2'b11);

  // R8
  err_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(cmd_valid || isr_wr));

  // R7
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_src == 2'b00 && cur_div_exp == '0 && !main_osc_off && !pll_off));
endmodule

bind cpu_clk_speed cpu_clk_speed_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .main_tick(main_tick), .rtc_tick(rtc_tick),
  .pll_tick(pll_tick), .cmd_valid(cmd_valid), .isr_wr(isr_wr),
  .core_en(core_en), .timer_en(timer_en), .main_osc_off(main_osc_off),
  .pll_off(pll_off), .cmd_err(cmd_err), .cur_src(cur_src),
  .cur_div_exp(cur_div_exp)
);

// File: tb/cpu_clk_speed_test.sv
`timescale 1ns/1ps
module cpu_clk_speed_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic main_valid = 1'b1, rtc_valid = 1'b1, pll_valid = 1'b1;
  logic cmd_valid = 1'b0, isr_wr = 1'b0, irq_enter = 1'b0, irq_return = 1'b0;
  logic [7:0] cmd_data = 8'h00, isr_data = 8'h00;
  logic core_en, timer_en, main_osc_off, pll_off, cmd_err;
  logic [1:0] cur_src;
  logic [2:0] cur_div_exp;
  logic [15:0] cyc = '0;
  logic main_tick, rtc_tick, pll_tick;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1'b1;
  // Main oscillator period 2, RTC period 8, PLL period 1.
  assign main_tick = ~cyc[0];
  assign rtc_tick  = (cyc[2:0] == 3'd0);
  assign pll_tick  = 1'b1;

  cpu_clk_speed uut (
    .clk(clk), .rst(rst), .main_tick(main_tick), .rtc_tick(rtc_tick),
    .pll_tick(pll_tick), .main_valid(main_valid), .rtc_valid(rtc_valid),
    .pll_valid(pll_valid), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .isr_wr(isr_wr), .isr_data(isr_data), .irq_enter(irq_enter),
    .irq_return(irq_return), .core_en(core_en), .timer_en(timer_en),
    .main_osc_off(main_osc_off), .pll_off(pll_off), .cmd_err(cmd_err),
    .cur_src(cur_src), .cur_div_exp(cur_div_exp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!core_en);
  endtask

  task automatic measure(output int n);
    wait_pulse();
    n = 0;
    do begin @(negedge clk); n++; end while (!core_en);
  endtask

  task automatic send_cmd(input logic [7:0] v, output logic err);
    @(negedge clk); cmd_data = v; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0; err = cmd_err;
  endtask

  task automatic pulse_irq(input bit enter);
    @(negedge clk);
    if (enter) irq_enter = 1'b1; else irq_return = 1'b1;
    @(negedge clk); irq_enter = 1'b0; irq_return = 1'b0;
  endtask

  task automatic settle_and_check(input int exp_iv, input string tag);
    int n;
    repeat (300) @(negedge clk);
    measure(n);
    chk(n == exp_iv, tag, n, exp_iv);
  endtask

  task automatic t_reset();
    int n;
    chk(cur_src == 2'd0 && cur_div_exp == 3'd0, "R7 reset setting", {cur_src, cur_div_exp}, 0);
    chk(!main_osc_off && !pll_off, "R7 reset off outputs", {main_osc_off, pll_off}, 0);
    measure(n);
    chk(n == 2, "R1 reset interval", n, 2);
  endtask

  task automatic t_divide();
    logic e;
    send_cmd(8'h03, e);                 // main, exp 3
    chk(!e, "R1 accept main/8", e, 0);
    settle_and_check(16, "R1 main div 8");
    send_cmd(8'h17, e);                 // PLL, exp 7
    settle_and_check(128, "R1 R3 pll div 128");
    chk(cur_src == 2'd2 && cur_div_exp == 3'd7, "R3 pll selected", {cur_src, cur_div_exp}, 23);
  endtask

  task automatic t_sources_timer();
    logic e;
    int n;
    send_cmd(8'h08, e);                 // RTC, exp 0
    settle_and_check(8, "R3 rtc div 1");
    send_cmd(8'h0A, e);                 // RTC, exp 2
    settle_and_check(32, "R1 rtc div 4");
    n = 0;
    do @(negedge clk); while (!timer_en);
    do begin @(negedge clk); n++; end while (!timer_en);
    chk(n == 8, "R2 timer undivided", n, 8);
  endtask

  task automatic t_boundary();
    logic e;
    int n;
    send_cmd(8'h04, e);                 // main, exp 4 -> interval 32
    settle_and_check(32, "R1 main div 16");
    wait_pulse();
    cmd_data = 8'h00; cmd_valid = 1'b1; // main, exp 0
    @(negedge clk); cmd_valid = 1'b0; n = 1;
    while (!core_en) begin @(negedge clk); n++; end
    chk(n == 32, "R5 old spacing kept", n, 32);
    n = 0;
    do begin @(negedge clk); n++; end while (!core_en);
    chk(n == 2, "R9 new spacing after wrap", n, 2);
  endtask

  task automatic t_disable();
    logic e;
    send_cmd(8'h30, e);                 // PLL, main off
    chk(!e, "R4 accept main off", e, 0);
    repeat (50) @(negedge clk);
    chk(main_osc_off && !pll_off, "R4 main off only", {main_osc_off, pll_off}, 2);
    send_cmd(8'h48, e);                 // RTC, PLL off
    repeat (50) @(negedge clk);
    chk(!main_osc_off && pll_off, "R4 pll off only", {main_osc_off, pll_off}, 1);
  endtask

  task automatic t_reject();
    logic e;
    send_cmd(8'h01, e);                 // main, exp 1 (accepted)
    repeat (50) @(negedge clk);
    send_cmd(8'h18, e);
    chk(e, "R8 reserved source error", e, 1);
    @(negedge clk);
    chk(!cmd_err, "R8 error one cycle", cmd_err, 0);
    send_cmd(8'h23, e);
    chk(e, "R8 main with own off bit", e, 1);
    send_cmd(8'h81, e);
    chk(e, "R8 bit 7 set", e, 1);
    pll_valid = 1'b0;
    send_cmd(8'h10, e);
    chk(e, "R8 pll not valid", e, 1);
    pll_valid = 1'b1;
    repeat (50) @(negedge clk);
    chk(cur_src == 2'd0 && cur_div_exp == 3'd1, "R8 setting kept", {cur_src, cur_div_exp}, 1);
  endtask

  task automatic t_interrupt();
    logic e;
    send_cmd(8'h03, e);                 // normal: main, exp 3
    @(negedge clk); isr_data = 8'h12; isr_wr = 1'b1;   // PLL, exp 2
    @(negedge clk); isr_wr = 1'b0;
    chk(!cmd_err, "R10 isr write accepted", cmd_err, 0);
    repeat (50) @(negedge clk);
    chk(cur_src == 2'd0, "R10 isr write no effect yet", cur_src, 0);
    pulse_irq(1'b1);
    settle_and_check(4, "R6 isr speed");
    chk(cur_src == 2'd2 && cur_div_exp == 3'd2, "R6 isr setting", {cur_src, cur_div_exp}, 18);
    pulse_irq(1'b1);
    pulse_irq(1'b0);
    repeat (50) @(negedge clk);
    chk(cur_src == 2'd2, "R10 nested still isr", cur_src, 2);
    pulse_irq(1'b0);
    settle_and_check(16, "R6 normal restored");
    chk(cur_src == 2'd0 && cur_div_exp == 3'd3, "R10 normal kept", {cur_src, cur_div_exp}, 3);
    pulse_irq(1'b0);
    repeat (50) @(negedge clk);
    chk(cur_src == 2'd0 && cur_div_exp == 3'd3, "R10 stray return ignored", {cur_src, cur_div_exp}, 3);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_divide();
    t_sources_timer();
    t_boundary();
    t_disable();
    t_reject();
    t_interrupt();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule